// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the per-source state for a bank of interrupt sources and decides when each source is offered to a presentation unit. Each source is fixed at build time as either level-sensitive or message-signalled. For every source the block keeps a destination server, a priority, a saved priority and four status flags: asserted, sent, rejected and masked-pending. Source input events update this state. When an event or a configuration change makes a source eligible, the block offers the source's global number, server and priority on a delivery port with a valid/ready handshake.

The presentation unit sends three kinds of notice back to the block. A reject marks a delivered source as refused. An end-of-interrupt frees a level source so it can be offered again. A resend request starts a sweep over the whole bank, one source per clock, which replays refused messages and re-offers eligible level sources. A configuration port provides four operations: route a source (server and priority), read a route back, disable a source and enable it again. Disable and enable use the saved priority. Global source numbers are a base offset plus the local index. A request outside the bank, or a route naming a server that does not exist, is answered with an error flag and changes nothing.

Only one operation touches the source table in any cycle. Notices from the presentation unit always win. After them come configuration requests, then sweep steps, then source events. Any operation that might deliver waits while a delivery is still unacknowledged.

Top module: `intsrc_ctrl`

## Requirements
- R1: After reset every source reads back with server 0 and priority 0xFF. All flags are clear, no delivery is offered and `resend_done` is low.
- R2: Priority 0xFF masks a source. A masked source is never delivered, and `dlv_prio` is never 0xFF while `dlv_valid` is high.
- R3: A message event (`ev_val`=1) on an unmasked message source is offered on the edge that accepts it. The delivery carries `dlv_num` = base + index and the source's server and priority, and it holds until `dlv_ready` is sampled high.
- R4: A message event on a masked message source sets masked-pending and is not delivered. A later route or enable that leaves the priority below 0xFF delivers the source once and clears the flag.
- R5: A level source copies `ev_val` into its asserted flag. It is delivered only when it is unmasked, asserted and not sent, and delivery sets sent. A repeated assertion while sent gives no delivery.
- R6: A reject (`pu_kind`=0) sets rejected and clears sent. A still-asserted level source is then offered again by the next sweep, and a de-asserted one is not.
- R7: A resend notice (`pu_kind`=2) sweeps indices 0 to N-1, one per cycle. Each message source with rejected set has the flag cleared and is re-offered if unmasked. `resend_done` pulses for one cycle N cycles after the notice when no delivery stalls the sweep. A second sweep gives no duplicate.
- R8: An end-of-interrupt (`pu_kind`=1) clears sent on a level source. It has no effect on a message source: a rejected message is still replayed by the next sweep.
- R9: Disable (`cfg_op`=2) sets priority 0xFF and saves the previous priority. Enable (`cfg_op`=3) copies the saved priority back into the priority. Route (`cfg_op`=0) writes server, priority and saved priority.
- R10: A configuration number outside [base, base+N), or a route whose server is at or above the server count, returns `rsp_err`=1, leaves the state unchanged and causes no delivery.
- R11: Every accepted configuration request gets `rsp_valid` one cycle later. A read (`cfg_op`=1) returns the source's current server and priority.
- R12: Notices are accepted every cycle, even while a delivery is pending. `cfg_ready` and `ev_ready` are low while a delivery is unacknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Source event request |
| ev_idx | input | IDX_W | Local index of the source |
| ev_val | input | 1 | Level value, or 1 for a message |
| ev_ready | output | 1 | Event accepted this cycle |
| cfg_valid | input | 1 | Configuration request |
| cfg_op | input | 2 | 0 route, 1 read, 2 disable, 3 enable |
| cfg_num | input | NUM_W | Global source number |
| cfg_server | input | SRV_W | Server for route |
| cfg_prio | input | PRIO_W | Priority for route |
| cfg_ready | output | 1 | Configuration accepted this cycle |
| rsp_valid | output | 1 | Configuration response |
| rsp_err | output | 1 | Request rejected as invalid |
| rsp_server | output | SRV_W | Server returned by a read |
| rsp_prio | output | PRIO_W | Priority returned by a read |
| pu_valid | input | 1 | Notice from the presentation unit |
| pu_kind | input | 2 | 0 reject, 1 end-of-interrupt, 2 resend |
| pu_num | input | NUM_W | Global source number of the notice |
| dlv_valid | output | 1 | Delivery offered |
| dlv_ready | input | 1 | Presentation unit takes the delivery |
| dlv_num | output | NUM_W | Global source number delivered |
| dlv_server | output | SRV_W | Destination server |
| dlv_prio | output | PRIO_W | Delivered priority |
| resend_done | output | 1 | One-cycle pulse when a sweep finishes |

## Verification
The flags cannot be read back. A wrong flag shows up only as a delivery that is missing or repeated, either on the next event for that source or in the next sweep, which ends N cycles later. The bench therefore counts deliveries across whole sweeps, and not only after single events. A wrong route or a priority that was not saved shows up on the very next read, or in the fields of the first delivery after an enable. An arbitration error shows as a ready that is high while a delivery is pending, or as a notice that was lost, and a replay expected in a later sweep would then be missing.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;

  // status flags, bit 0 upward: asserted, sent, rejected, masked-pending
  typedef struct packed {
    logic mpend;
    logic rej;
    logic sent;
    logic asrt;
  } stat_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_EVENT, OP_SET, OP_OFF, OP_ON, OP_REJECT, OP_EOI, OP_SWEEP
  } op_e;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PU, SEL_CFG, SEL_SWEEP, SEL_EV
  } sel_e;

  localparam logic [1:0] CFG_SET = 2'd0;
  localparam logic [1:0] CFG_GET = 2'd1;
  localparam logic [1:0] CFG_OFF = 2'd2;
  localparam logic [1:0] CFG_ON  = 2'd3;

  localparam logic [1:0] PU_REJECT = 2'd0;
  localparam logic [1:0] PU_EOI    = 2'd1;
  localparam logic [1:0] PU_RESEND = 2'd2;

endpackage

// File: rtl/intsrc_table.sv
module intsrc_table
  import intsrc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int SRV_W   = 3,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SRV_W-1:0]  wr_srv,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic [PRIO_W-1:0] wr_sprio,
  input  stat_t             wr_stat,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [SRV_W-1:0]  rd_srv,
  output logic [PRIO_W-1:0] rd_prio,
  output logic [PRIO_W-1:0] rd_sprio,
  output stat_t             rd_stat
);

  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic [SRV_W-1:0]  srv_q   [NUM_SRC];
  logic [PRIO_W-1:0] prio_q  [NUM_SRC];
  logic [PRIO_W-1:0] sprio_q [NUM_SRC];
  stat_t             stat_q  [NUM_SRC];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (rst) begin
        srv_q[i]   <= '0;
        prio_q[i]  <= MASKED;
        sprio_q[i] <= MASKED;
        stat_q[i]  <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        srv_q[i]   <= wr_srv;
        prio_q[i]  <= wr_prio;
        sprio_q[i] <= wr_sprio;
        stat_q[i]  <= wr_stat;
      end
    end
  end

  assign rd_srv   = srv_q[rd_idx];
  assign rd_prio  = prio_q[rd_idx];
  assign rd_sprio = sprio_q[rd_idx];
  assign rd_stat  = stat_q[rd_idx];

endmodule

// File: rtl/intsrc_eval.sv
module intsrc_eval
  import intsrc_pkg::*;
#(
  parameter int SRV_W  = 3,
  parameter int PRIO_W = 8
) (
  input  op_e               op,
  input  logic              is_level,
  input  logic              ev_val,
  input  logic [SRV_W-1:0]  cur_srv,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic [PRIO_W-1:0] cur_sprio,
  input  stat_t             cur_stat,
  input  logic [SRV_W-1:0]  pay_srv,
  input  logic [PRIO_W-1:0] pay_prio,
  output logic [SRV_W-1:0]  nx_srv,
  output logic [PRIO_W-1:0] nx_prio,
  output logic [PRIO_W-1:0] nx_sprio,
  output stat_t             nx_stat,
  output logic              wr,
  output logic              fire
);

  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic chk_lvl, chk_msg;

  always_comb begin
    nx_srv   = cur_srv;
    nx_prio  = cur_prio;
    nx_sprio = cur_sprio;
    nx_stat  = cur_stat;
    wr       = 1'b0;
    fire     = 1'b0;
    chk_lvl  = 1'b0;
    chk_msg  = 1'b0;
    case (op)
      OP_EVENT: begin
        wr = 1'b1;
        if (is_level) begin
          nx_stat.asrt = ev_val;
          chk_lvl      = 1'b1;
        end else if (ev_val) begin
          if (cur_prio == MASKED) nx_stat.mpend = 1'b1;
          else                    fire          = 1'b1;
        end
      end
      OP_SET: begin
        wr       = 1'b1;
        nx_srv   = pay_srv;
        nx_prio  = pay_prio;
        nx_sprio = pay_prio;
        chk_lvl  = 1'b1;
        chk_msg  = 1'b1;
      end
      OP_OFF: begin
        wr       = 1'b1;
        nx_prio  = MASKED;
        nx_sprio = cur_prio;
        chk_lvl  = 1'b1;
        chk_msg  = 1'b1;
      end
      OP_ON: begin
        wr      = 1'b1;
        nx_prio = cur_sprio;
        chk_lvl = 1'b1;
        chk_msg = 1'b1;
      end
      OP_REJECT: begin
        wr           = 1'b1;
        nx_stat.rej  = 1'b1;
        nx_stat.sent = 1'b0;
      end
      OP_EOI: begin
        wr = 1'b1;
        if (is_level) nx_stat.sent = 1'b0;
      end
      OP_SWEEP: begin
        wr = 1'b1;
        if (is_level) begin
          chk_lvl = 1'b1;
        end else if (cur_stat.rej) begin
          nx_stat.rej = 1'b0;
          if (cur_prio != MASKED) fire = 1'b1;
        end
      end
      default: ;
    endcase

    // a level source goes out once per assertion until reject or EOI clears sent
    if (is_level && chk_lvl && (nx_prio != MASKED) && nx_stat.asrt && !nx_stat.sent) begin
      nx_stat.sent = 1'b1;
      fire         = 1'b1;
    end
    // a message latched while masked goes out when the priority becomes valid
    if (!is_level && chk_msg && nx_stat.mpend && (nx_prio != MASKED)) begin
      nx_stat.mpend = 1'b0;
      fire          = 1'b1;
    end
  end

endmodule

// File: rtl/intsrc_sched.sv
module intsrc_sched
  import intsrc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pu_valid,
  input  logic [1:0]       pu_kind,
  input  logic             cfg_valid,
  input  logic             ev_valid,
  input  logic             slot_busy,
  output sel_e             sel,
  output logic             cfg_ready,
  output logic             ev_ready,
  output logic [IDX_W-1:0] sweep_idx,
  output logic             resend_done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

  logic sweep_act;

  always_comb begin
    if (pu_valid)                      sel = SEL_PU;
    else if (cfg_valid && !slot_busy)  sel = SEL_CFG;
    else if (sweep_act && !slot_busy)  sel = SEL_SWEEP;
    else if (ev_valid && !slot_busy)   sel = SEL_EV;
    else                               sel = SEL_NONE;
  end

  assign cfg_ready = !pu_valid && !slot_busy;
  assign ev_ready  = !pu_valid && !cfg_valid && !sweep_act && !slot_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_act   <= 1'b0;
      sweep_idx   <= '0;
      resend_done <= 1'b0;
    end else begin
      resend_done <= 1'b0;
      if (pu_valid && (pu_kind == PU_RESEND)) begin
        sweep_act <= 1'b1;
        sweep_idx <= '0;
      end else if (sel == SEL_SWEEP) begin
        if (sweep_idx == LAST) begin
          sweep_act   <= 1'b0;
          sweep_idx   <= '0;
          resend_done <= 1'b1;
        end else begin
          sweep_idx <= sweep_idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/intsrc_ctrl.sv
module intsrc_ctrl
  import intsrc_pkg::*;
#(
  parameter int                   NUM_SRC     = 16,
  parameter int                   NUM_SERVERS = 5,
  parameter int                   SRV_W       = 3,
  parameter int                   PRIO_W      = 8,
  parameter int                   NUM_W       = 16,
  parameter int                   SRC_BASE    = 16,
  parameter logic [NUM_SRC-1:0]   LEVEL_MAP   = 16'h000F,
  localparam int                  IDX_W       = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  input  logic [IDX_W-1:0]  ev_idx,
  input  logic              ev_val,
  output logic              ev_ready,
  input  logic              cfg_valid,
  input  logic [1:0]        cfg_op,
  input  logic [NUM_W-1:0]  cfg_num,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  output logic              cfg_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [SRV_W-1:0]  rsp_server,
  output logic [PRIO_W-1:0] rsp_prio,
  input  logic              pu_valid,
  input  logic [1:0]        pu_kind,
  input  logic [NUM_W-1:0]  pu_num,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [NUM_W-1:0]  dlv_num,
  output logic [SRV_W-1:0]  dlv_server,
  output logic [PRIO_W-1:0] dlv_prio,
  output logic              resend_done
);

  localparam bit FULL_IDX = (NUM_SRC == (1 << IDX_W));
  localparam bit FULL_SRV = (NUM_SERVERS >= (1 << SRV_W));

  sel_e              sel;
  op_e               op;
  logic [IDX_W-1:0]  idx, sweep_idx;
  logic              cfg_err, ev_ok, srv_ok, rng_ok, is_level;
  logic [NUM_W-1:0]  num_sel;
  logic [NUM_W:0]    diff;
  logic [SRV_W-1:0]  rd_srv, nx_srv;
  logic [PRIO_W-1:0] rd_prio, rd_sprio, nx_prio, nx_sprio;
  stat_t             rd_stat, nx_stat;
  logic              wr, fire;

  // range checks; the compare is dropped when the field width already bounds it
  generate
    if (FULL_IDX) begin : g_ev_full
      assign ev_ok = 1'b1;
    end else begin : g_ev_part
      assign ev_ok = (ev_idx < IDX_W'(NUM_SRC));
    end
    if (FULL_SRV) begin : g_srv_full
      assign srv_ok = 1'b1;
    end else begin : g_srv_part
      assign srv_ok = (cfg_server < SRV_W'(NUM_SERVERS));
    end
  endgenerate

  assign num_sel = (sel == SEL_PU) ? pu_num : cfg_num;
  assign diff    = {1'b0, num_sel} - (NUM_W + 1)'(SRC_BASE);
  assign rng_ok  = !diff[NUM_W] && (diff < (NUM_W + 1)'(NUM_SRC));

  always_comb begin
    op      = OP_NONE;
    idx     = diff[IDX_W-1:0];
    cfg_err = 1'b0;
    case (sel)
      SEL_PU: begin
        if (rng_ok && (pu_kind == PU_REJECT)) op = OP_REJECT;
        if (rng_ok && (pu_kind == PU_EOI))    op = OP_EOI;
      end
      SEL_CFG: begin
        if (!rng_ok || ((cfg_op == CFG_SET) && !srv_ok)) begin
          cfg_err = 1'b1;
        end else begin
          case (cfg_op)
            CFG_SET: op = OP_SET;
            CFG_OFF: op = OP_OFF;
            CFG_ON:  op = OP_ON;
            default: op = OP_NONE;
          endcase
        end
      end
      SEL_SWEEP: begin
        idx = sweep_idx;
        op  = OP_SWEEP;
      end
      SEL_EV: begin
        idx = ev_idx;
        if (ev_ok) op = OP_EVENT;
      end
      default: ;
    endcase
  end

  assign is_level = LEVEL_MAP[idx];

  intsrc_sched #(.NUM_SRC(NUM_SRC)) u_sched (
    .clk         (clk),
    .rst         (rst),
    .pu_valid    (pu_valid),
    .pu_kind     (pu_kind),
    .cfg_valid   (cfg_valid),
    .ev_valid    (ev_valid),
    .slot_busy   (dlv_valid),
    .sel         (sel),
    .cfg_ready   (cfg_ready),
    .ev_ready    (ev_ready),
    .sweep_idx   (sweep_idx),
    .resend_done (resend_done)
  );

  intsrc_table #(.NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr),
    .wr_idx   (idx),
    .wr_srv   (nx_srv),
    .wr_prio  (nx_prio),
    .wr_sprio (nx_sprio),
    .wr_stat  (nx_stat),
    .rd_idx   (idx),
    .rd_srv   (rd_srv),
    .rd_prio  (rd_prio),
    .rd_sprio (rd_sprio),
    .rd_stat  (rd_stat)
  );

  intsrc_eval #(.SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_eval (
    .op        (op),
    .is_level  (is_level),
    .ev_val    (ev_val),
    .cur_srv   (rd_srv),
    .cur_prio  (rd_prio),
    .cur_sprio (rd_sprio),
    .cur_stat  (rd_stat),
    .pay_srv   (cfg_server),
    .pay_prio  (cfg_prio),
    .nx_srv    (nx_srv),
    .nx_prio   (nx_prio),
    .nx_sprio  (nx_sprio),
    .nx_stat   (nx_stat),
    .wr        (wr),
    .fire      (fire)
  );

  // delivery slot and configuration response, both registered
  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid  <= 1'b0;
      dlv_num    <= '0;
      dlv_server <= '0;
      dlv_prio   <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_server <= '0;
      rsp_prio   <= '0;
    end else begin
      if (fire) begin
        dlv_valid  <= 1'b1;
        dlv_num    <= NUM_W'(SRC_BASE) + NUM_W'(idx);
        dlv_server <= nx_srv;
        dlv_prio   <= nx_prio;
      end else if (dlv_ready) begin
        dlv_valid  <= 1'b0;
      end
      rsp_valid <= (sel == SEL_CFG);
      rsp_err   <= cfg_err;
      if ((sel == SEL_CFG) && !cfg_err && (cfg_op == CFG_GET)) begin
        rsp_server <= rd_srv;
        rsp_prio   <= rd_prio;
      end else begin
        rsp_server <= '0;
        rsp_prio   <= '0;
      end
    end
  end

endmodule

// File: rtl/intsrc_ctrl_chk.sv
module intsrc_ctrl_chk #(
  parameter int NUM_SRC     = 16,
  parameter int NUM_SERVERS = 5,
  parameter int SRV_W       = 3,
  parameter int PRIO_W      = 8,
  parameter int NUM_W       = 16,
  parameter int SRC_BASE    = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_valid,
  input logic              cfg_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              dlv_valid,
  input logic              dlv_ready,
  input logic [NUM_W-1:0]  dlv_num,
  input logic [SRV_W-1:0]  dlv_server,
  input logic [PRIO_W-1:0] dlv_prio,
  input logic              resend_done
);

  p_masked_never_sent_r2: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> (dlv_prio != {PRIO_W{1'b1}}));

  p_dlv_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(dlv_num) &&
                                   $stable(dlv_server) && $stable(dlv_prio)));

  p_dlv_num_range_r3: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> ((int'(dlv_num) >= SRC_BASE) && (int'(dlv_num) < SRC_BASE + NUM_SRC)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    resend_done |=> !resend_done);

  p_err_no_dlv_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> !$rose(dlv_valid));

  p_dlv_server_ok_r10: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> (int'(dlv_server) < NUM_SERVERS));

  p_rsp_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(cfg_valid && cfg_ready));

endmodule

bind intsrc_ctrl intsrc_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_SERVERS(NUM_SERVERS), .SRV_W(SRV_W),
  .PRIO_W(PRIO_W), .NUM_W(NUM_W), .SRC_BASE(SRC_BASE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_valid   (cfg_valid),
  .cfg_ready   (cfg_ready),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .dlv_valid   (dlv_valid),
  .dlv_ready   (dlv_ready),
  .dlv_num     (dlv_num),
  .dlv_server  (dlv_server),
  .dlv_prio    (dlv_prio),
  .resend_done (resend_done)
);

// File: tb/intsrc_ctrl_test.sv
module intsrc_ctrl_test;
  import intsrc_pkg::*;

  localparam int CLK_P = 10;
  localparam int NSRC  = 16;
  localparam int BASE  = 16;
  localparam int NV    = 6;
  // {index[4], server[3], priority[8], expect delivery[1]}
  localparam logic [15:0] VEC [NV] = '{
    {4'd4, 3'd1, 8'h10, 1'b1},
    {4'd5, 3'd4, 8'h00, 1'b1},
    {4'd6, 3'd2, 8'hFE, 1'b1},
    {4'd7, 3'd0, 8'hFF, 1'b0},
    {4'd0, 3'd3, 8'h05, 1'b1},
    {4'd8, 3'd2, 8'h40, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ev_valid = 0, ev_val = 0, ev_ready;
  logic [3:0] ev_idx = '0;
  logic cfg_valid = 0, cfg_ready;
  logic [1:0] cfg_op = '0;
  logic [15:0] cfg_num = '0;
  logic [2:0] cfg_server = '0;
  logic [7:0] cfg_prio = '0;
  logic rsp_valid, rsp_err;
  logic [2:0] rsp_server;
  logic [7:0] rsp_prio;
  logic pu_valid = 0;
  logic [1:0] pu_kind = '0;
  logic [15:0] pu_num = '0;
  logic dlv_valid, dlv_ready = 0;
  logic [15:0] dlv_num;
  logic [2:0] dlv_server;
  logic [7:0] dlv_prio;
  logic resend_done;

  int checks = 0, errors = 0;
  int nd, cyc;
  logic [15:0] lastn;

  always #(CLK_P/2) clk = ~clk;

  intsrc_ctrl uut (
    .clk(clk), .rst(rst),
    .ev_valid(ev_valid), .ev_idx(ev_idx), .ev_val(ev_val), .ev_ready(ev_ready),
    .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_num(cfg_num),
    .cfg_server(cfg_server), .cfg_prio(cfg_prio), .cfg_ready(cfg_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_server(rsp_server), .rsp_prio(rsp_prio),
    .pu_valid(pu_valid), .pu_kind(pu_kind), .pu_num(pu_num),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_num(dlv_num),
    .dlv_server(dlv_server), .dlv_prio(dlv_prio), .resend_done(resend_done)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every task starts just after a falling edge and ends on one
  task automatic do_cfg(logic [1:0] op, int num, int srv, int prio);
    cfg_valid = 1; cfg_op = op; cfg_num = 16'(num);
    cfg_server = 3'(srv); cfg_prio = 8'(prio);
    #1;
    while (!cfg_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic do_ev(int idx, logic val);
    ev_valid = 1; ev_idx = 4'(idx); ev_val = val;
    #1;
    while (!ev_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic do_pu(logic [1:0] kind, int num);
    pu_valid = 1; pu_kind = kind; pu_num = 16'(num);
    @(negedge clk);
    pu_valid = 0;
  endtask

  task automatic take();
    dlv_ready = 1;
    @(negedge clk);
    dlv_ready = 0;
  endtask

  task automatic sweep(output int n, output logic [15:0] ln, output int c);
    do_pu(PU_RESEND, 0);
    n = 0; c = 0; ln = '0;
    while (!resend_done) begin
      if (dlv_valid) begin n++; ln = dlv_num; dlv_ready = 1; end
      @(negedge clk);
      dlv_ready = 0;
      c++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 dlv_valid", dlv_valid, 0);
    check("R1 resend_done", resend_done, 0);
    do_cfg(CFG_GET, BASE + 5, 0, 0);
    check("R1 rsp_err", rsp_err, 0);
    check("R1 server", rsp_server, 0);
    check("R1 prio", rsp_prio, 8'hFF);

    // table walk: route, fire an event, check delivery
    for (int i = 0; i < NV; i++) begin
      logic [3:0] vi; logic [2:0] vs; logic [7:0] vp; logic ve;
      {vi, vs, vp, ve} = VEC[i];
      do_cfg(CFG_SET, BASE + int'(vi), int'(vs), int'(vp));
      check("R11 rsp_valid", rsp_valid, 1);
      do_ev(int'(vi), 1'b1);
      check("R3/R2 delivery", dlv_valid, ve);
      if (ve) begin
        check("R3 num", dlv_num, BASE + int'(vi));
        check("R3 server", dlv_server, vs);
        check("R3 prio", dlv_prio, vp);
        #1;
        check("R12 cfg_ready low", cfg_ready, 0);
        check("R12 ev_ready low", ev_ready, 0);
        @(negedge clk);
        check("R3 held", dlv_valid, 1);
        take();
        check("R3 released", dlv_valid, 0);
      end
      do_cfg(CFG_GET, BASE + int'(vi), 0, 0);
      check("R11 get server", rsp_server, vs);
      check("R11 get prio", rsp_prio, vp);
    end

    // R9, R4: disable / enable on message source 13
    do_cfg(CFG_SET, BASE + 13, 3, 9);
    do_cfg(CFG_OFF, BASE + 13, 0, 0);
    check("R9 off ok", rsp_err, 0);
    do_cfg(CFG_GET, BASE + 13, 0, 0);
    check("R9 off prio", rsp_prio, 8'hFF);
    check("R9 off server", rsp_server, 3);
    do_ev(13, 1'b1);
    check("R4 masked no dlv", dlv_valid, 0);
    do_cfg(CFG_ON, BASE + 13, 0, 0);
    check("R4 on delivers", dlv_valid, 1);
    check("R4 on num", dlv_num, BASE + 13);
    check("R9 on prio", dlv_prio, 9);
    take();
    do_cfg(CFG_GET, BASE + 13, 0, 0);
    check("R9 restored", rsp_prio, 9);
    do_cfg(CFG_ON, BASE + 13, 0, 0);
    check("R4 pending cleared", dlv_valid, 0);

    // R4: route makes a latched message go out
    do_ev(14, 1'b1);
    check("R4 masked src14", dlv_valid, 0);
    do_cfg(CFG_SET, BASE + 14, 4, 2);
    check("R4 set delivers", dlv_valid, 1);
    check("R4 set server", dlv_server, 4);
    check("R4 set prio", dlv_prio, 2);
    take();

    // R7, R12: reject during pending delivery, then sweep replay
    do_cfg(CFG_SET, BASE + 10, 1, 3);
    do_ev(10, 1'b1);
    do_pu(PU_REJECT, BASE + 10);
    check("R12 dlv still pending", dlv_valid, 1);
    take();
    sweep(nd, lastn, cyc);
    check("R7 replay count", nd, 1);
    check("R7 replay num", lastn, BASE + 10);
    sweep(nd, lastn, cyc);
    check("R7 no duplicate", nd, 0);
    check("R7 sweep length", cyc, NSRC);

    // R5, R8: level source 1 with EOI
    do_cfg(CFG_SET, BASE + 1, 2, 4);
    do_ev(1, 1'b1);
    check("R5 level delivers", dlv_valid, 1);
    check("R5 level num", dlv_num, BASE + 1);
    take();
    do_ev(1, 1'b1);
    check("R5 sent blocks", dlv_valid, 0);
    sweep(nd, lastn, cyc);
    check("R8 before eoi", nd, 0);
    do_pu(PU_EOI, BASE + 1);
    sweep(nd, lastn, cyc);
    check("R8 after eoi count", nd, 1);
    check("R8 after eoi num", lastn, BASE + 1);

    // R8: EOI leaves a message's rejected flag alone
    do_cfg(CFG_SET, BASE + 12, 0, 7);
    do_ev(12, 1'b1);
    take();
    do_pu(PU_REJECT, BASE + 12);
    do_pu(PU_EOI, BASE + 12);
    sweep(nd, lastn, cyc);
    check("R8 msg eoi no effect", nd, 1);
    check("R8 msg replay num", lastn, BASE + 12);

    // R6, R5: level source 2 de-asserted after reject
    do_cfg(CFG_SET, BASE + 2, 1, 6);
    do_ev(2, 1'b1);
    take();
    do_pu(PU_REJECT, BASE + 2);
    do_ev(2, 1'b0);
    check("R5 deassert no dlv", dlv_valid, 0);
    sweep(nd, lastn, cyc);
    check("R6 deasserted no replay", nd, 0);
    do_ev(2, 1'b1);
    check("R5 reassert delivers", dlv_valid, 1);
    take();

    // R6: still-asserted level source 3 replayed after reject
    do_cfg(CFG_SET, BASE + 3, 0, 8);
    do_ev(3, 1'b1);
    take();
    do_pu(PU_REJECT, BASE + 3);
    sweep(nd, lastn, cyc);
    check("R6 replay count", nd, 1);
    check("R6 replay num", lastn, BASE + 3);

    // R10: invalid requests
    do_cfg(CFG_GET, BASE - 1, 0, 0);
    check("R10 below range", rsp_err, 1);
    check("R10 rsp_valid", rsp_valid, 1);
    do_cfg(CFG_GET, BASE + NSRC, 0, 0);
    check("R10 above range", rsp_err, 1);
    do_cfg(CFG_OFF, BASE + 24, 0, 0);
    check("R10 off out of range", rsp_err, 1);
    do_cfg(CFG_SET, BASE + 11, 5, 1);
    check("R10 bad server", rsp_err, 1);
    check("R10 no delivery", dlv_valid, 0);
    do_cfg(CFG_GET, BASE + 11, 0, 0);
    check("R10 state unchanged prio", rsp_prio, 8'hFF);
    check("R10 state unchanged server", rsp_server, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule